// File: doc/BRIEF.md
# PCI Bus Initiator Sequencer

This block is the master side of a 32-bit PCI interface. A local agent hands it one request: a command code, a 64-bit address, byte enables, a direction and a burst length. The block then runs the whole bus transaction. It drives the shared address/data and command/byte-enable lines, asserts FRAME# and IRDY#, and samples DEVSEL#, TRDY# and STOP# from the target. When the transaction is over it reports a completion status, and for reads it returns each data word as it is taken from the bus.

When the upper half of the address is non-zero, the block issues two address phases. It watches for the target to claim the cycle and gives up with a master abort if no claim arrives in time. At the end of a transaction it drives its control lines high for a clock before it lets go of them. While the bus is idle and the grant is held, it parks on the shared lines. Every output enable is a register, so each hand-over of the bus passes through a clock in which nobody drives. Bus lines use separate in, out and enable pins, and all control signals are active low on the bus side.

Top module: `pci_init_seq`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` is high, `gnt_n` is low and the block is idle. In the clock after that edge, `frame_o` is low and enabled. If `req_addr[63:32]` is zero, the same clock carries `req_addr[31:0]` on `ad_o` and `req_cmd` on `cbe_o`.
- R2: If `req_addr[63:32]` is non-zero, the first address clock carries `req_addr[31:0]` with command code 4'b1101 on `cbe_o`. The next clock carries `req_addr[63:32]` with `req_cmd`.
- R3: A data phase completes on an edge where TRDY# is sampled low while IRDY# is driven low. On every data phase `cbe_o` shows `req_be`. For a write, phase i shows `wr_data`, which the block fetches while `wr_idx` equals i. For a read, the word on `ad_i` is returned on `rd_data` with a one-clock `rd_valid` pulse in the following clock.
- R4: A burst has `req_len` data phases, and a length of 0 means one phase. FRAME# is high during the final data phase and low during every earlier one. IRDY#, once asserted, stays low until its data phase completes, unless STOP# or a master abort ends the cycle.
- R5: If DEVSEL# is not sampled low on any of the five edges after the edge that asserts FRAME#, the fifth edge raises FRAME# and the next edge raises IRDY#. The block then reports status 2'b01.
- R6: If STOP# is sampled low, FRAME# goes high at the next edge unless it is already high, and IRDY# goes high on the edge after that. The status is 2'b11 (retry) if no data phase completed, and 2'b10 (disconnect) otherwise.
- R7: A normal burst reports status 2'b00. FRAME# and IRDY# are driven high for at least one clock before their enables drop. `done` pulses for one clock in the clock after the enables drop. After a normal burst, that pulse comes exactly one clock after the last data phase.
- R8: The enables of `ad_o` and `cbe_o` drop on the same edge that raises IRDY# at the end of a cycle. During read data phases `ad_oe` is low. An enable never rises in the clock right after FRAME# was enabled.
- R9: On every edge where the block is idle and `gnt_n` is low, it parks. `ad_oe` and `cbe_oe` are high from the next clock, with zero on both buses. They drop one edge after `gnt_n` goes high.
- R10: While `gnt_n` is high, `req_valid` is ignored: `busy` and `frame_oe` stay low. `busy` is high from the accepting edge until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request strobe |
| req_cmd | input | 4 | Bus command for the transaction |
| req_addr | input | 64 | Target address; a non-zero upper half selects two address phases |
| req_be | input | 4 | Active-low byte enables for all data phases |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_len | input | LENW | Number of data phases (0 treated as 1) |
| wr_data | input | 32 | Write word for phase `wr_idx` |
| wr_idx | output | LENW | Index of the write word being fetched |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| status | output | 2 | 00 ok, 01 master abort, 10 disconnect, 11 retry |
| rd_data | output | 32 | Read word taken from the bus |
| rd_valid | output | 1 | `rd_data` holds a new word |
| gnt_n | input | 1 | Bus grant, active low |
| ad_o | output | 32 | Address/data out |
| ad_oe | output | 1 | Address/data drive enable |
| ad_i | input | 32 | Address/data in |
| cbe_o | output | 4 | Command/byte-enable out |
| cbe_oe | output | 1 | Command/byte-enable drive enable |
| frame_o | output | 1 | FRAME# out |
| frame_oe | output | 1 | FRAME# drive enable |
| irdy_o | output | 1 | IRDY# out |
| irdy_oe | output | 1 | IRDY# drive enable |
| devsel_n | input | 1 | DEVSEL# sampled from the bus |
| trdy_n | input | 1 | TRDY# sampled from the bus |
| stop_n | input | 1 | STOP# sampled from the bus |

## Verification
The hardest situation to reach is a target ending the burst with STOP# while FRAME# is still low and data is still moving. Only in that case does the block have to finish a transfer, raise FRAME#, and count one more transfer on the next edge before it releases IRDY#. The bench reaches it with a scripted target that asserts DEVSEL# on the first edge, holds TRDY# from the first data edge and raises STOP# one edge later, all during a four-phase burst. A second script never claims the cycle, so the five-edge abort window runs out for both single and dual address phases.

// File: rtl/pci_init_seq.sv
module pci_init_seq #(
  parameter int LENW    = 4,
  parameter int MA_CLKS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [3:0]      req_cmd,
  input  logic [63:0]     req_addr,
  input  logic [3:0]      req_be,
  input  logic            req_write,
  input  logic [LENW-1:0] req_len,
  input  logic [31:0]     wr_data,
  output logic [LENW-1:0] wr_idx,
  output logic            busy,
  output logic            done,
  output logic [1:0]      status,
  output logic [31:0]     rd_data,
  output logic            rd_valid,
  input  logic            gnt_n,
  output logic [31:0]     ad_o,
  output logic            ad_oe,
  input  logic [31:0]     ad_i,
  output logic [3:0]      cbe_o,
  output logic            cbe_oe,
  output logic            frame_o,
  output logic            frame_oe,
  output logic            irdy_o,
  output logic            irdy_oe,
  input  logic            devsel_n,
  input  logic            trdy_n,
  input  logic            stop_n
);
  localparam int DW = $clog2(MA_CLKS + 1);
  localparam logic [3:0] DUAL_CMD = 4'b1101;
  localparam logic [1:0] ST_OK = 2'b00, ST_ABORT = 2'b01, ST_DISC = 2'b10, ST_RETRY = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_DAC, S_ADDR, S_DATA, S_MABT, S_REL} st_t;

  st_t             st;
  logic [31:0]     hi_r;
  logic [3:0]      cmd_r, be_r;
  logic            wr_r, seen;
  logic [LENW-1:0] rem, xfers;
  logic [DW-1:0]   dcnt;
  logic            xfer, stp, claimed_late;

  assign xfer   = !trdy_n;
  assign stp    = !stop_n;
  assign busy   = (st != S_IDLE);
  assign wr_idx = (st == S_DATA) ? xfers + LENW'(1) : '0;
  assign claimed_late = !seen && devsel_n && (dcnt == DW'(MA_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hi_r <= '0; cmd_r <= '0; be_r <= '0; wr_r <= 1'b0; seen <= 1'b0;
      rem <= '0; xfers <= '0; dcnt <= '0;
      done <= 1'b0; status <= ST_OK; rd_data <= '0; rd_valid <= 1'b0;
      ad_o <= '0; ad_oe <= 1'b0; cbe_o <= '0; cbe_oe <= 1'b0;
      frame_o <= 1'b1; frame_oe <= 1'b0; irdy_o <= 1'b1; irdy_oe <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (st == S_DAC || st == S_ADDR || st == S_DATA) begin
        if (!devsel_n) seen <= 1'b1;
        if (dcnt != DW'(MA_CLKS)) dcnt <= dcnt + DW'(1);
      end
      case (st)
        S_IDLE: begin
          if (req_valid && !gnt_n) begin
            hi_r  <= req_addr[63:32];
            cmd_r <= req_cmd;
            be_r  <= req_be;
            wr_r  <= req_write;
            rem   <= (req_len == '0) ? LENW'(1) : req_len;
            xfers <= '0;
            dcnt  <= '0;
            seen  <= 1'b0;
            frame_o <= 1'b0; frame_oe <= 1'b1;
            irdy_o  <= 1'b1; irdy_oe  <= 1'b1;
            ad_o    <= req_addr[31:0];
            ad_oe   <= 1'b1; cbe_oe <= 1'b1;
            if (req_addr[63:32] != '0) begin
              cbe_o <= DUAL_CMD;
              st    <= S_DAC;
            end else begin
              cbe_o <= req_cmd;
              st    <= S_ADDR;
            end
          end else begin
            ad_oe  <= !gnt_n;
            cbe_oe <= !gnt_n;
            ad_o   <= '0;
            cbe_o  <= '0;
          end
        end
        S_DAC: begin
          ad_o  <= hi_r;
          cbe_o <= cmd_r;
          st    <= S_ADDR;
        end
        S_ADDR: begin
          irdy_o <= 1'b0;
          cbe_o  <= be_r;
          ad_oe  <= wr_r;
          ad_o   <= wr_r ? wr_data : '0;
          if (rem == LENW'(1)) frame_o <= 1'b1;
          st <= S_DATA;
        end
        S_DATA: begin
          if (claimed_late) begin
            frame_o <= 1'b1;
            st      <= S_MABT;
          end else begin
            if (xfer) begin
              xfers <= xfers + LENW'(1);
              rem   <= rem - LENW'(1);
              if (!wr_r) begin
                rd_data  <= ad_i;
                rd_valid <= 1'b1;
              end else begin
                ad_o <= wr_data;
              end
            end
            if (frame_o && (xfer || stp)) begin
              irdy_o <= 1'b1;
              ad_oe  <= 1'b0;
              cbe_oe <= 1'b0;
              status <= stp ? ((xfers == '0 && !xfer) ? ST_RETRY : ST_DISC) : ST_OK;
              st     <= S_REL;
            end else if (!frame_o && (stp || (xfer && rem == LENW'(2)))) begin
              frame_o <= 1'b1;
            end
          end
        end
        S_MABT: begin
          irdy_o <= 1'b1;
          ad_oe  <= 1'b0;
          cbe_oe <= 1'b0;
          status <= ST_ABORT;
          st     <= S_REL;
        end
        S_REL: begin
          frame_oe <= 1'b0;
          irdy_oe  <= 1'b0;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_addr_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && $fell(frame_o)) |-> (ad_oe && cbe_oe && irdy_o));

  assert_irdy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_oe && !irdy_o && trdy_n && stop_n && !devsel_n) |=> (irdy_oe && !irdy_o));

  assert_frame_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_oe && $rose(irdy_o)) |-> (frame_o && $past(frame_o)));

  assert_high_before_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_oe) |-> ($past(frame_o) && $past(irdy_o) && $fell(irdy_oe)));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> !$past(frame_oe));

  assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !gnt_n) |=> (ad_oe && cbe_oe));
endmodule

// File: tb/test_pci_init_seq.sv
module test_pci_init_seq;
  localparam int LENW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_write, gnt_n, devsel_n, trdy_n, stop_n;
  logic [3:0] req_cmd, req_be;
  logic [63:0] req_addr;
  logic [LENW-1:0] req_len, wr_idx;
  logic [31:0] wr_data, rd_data, ad_o, ad_i;
  logic busy, done, rd_valid, ad_oe, cbe_oe, frame_o, frame_oe, irdy_o, irdy_oe;
  logic [1:0] status;
  logic [3:0] cbe_o;
  logic [31:0] wbase, rbase;

  assign wr_data = wbase + 32'(wr_idx);

  pci_init_seq #(.LENW(LENW), .MA_CLKS(5)) i_pci_init_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_len(req_len),
    .wr_data(wr_data), .wr_idx(wr_idx), .busy(busy), .done(done), .status(status),
    .rd_data(rd_data), .rd_valid(rd_valid), .gnt_n(gnt_n), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .cbe_o(cbe_o), .cbe_oe(cbe_oe), .frame_o(frame_o), .frame_oe(frame_oe),
    .irdy_o(irdy_o), .irdy_oe(irdy_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n));

  int errors = 0, checks = 0;
  bit finished = 0;
  int t_d, t_t, t_s, t_len, nx;
  bit t_wr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rpat(input int i);
    return rbase ^ 32'(i * 7 + 1);
  endfunction

  task automatic target(input int k);
    devsel_n = !(t_d != 0 && k + 1 >= t_d);
    trdy_n   = !(t_t != 0 && k + 1 >= t_t);
    stop_n   = !(t_s != 0 && k + 1 >= t_s);
    if (irdy_oe && !irdy_o && !trdy_n) begin
      chk(cbe_o == req_be, "R3", "byte enables in data phase", 64'(cbe_o), 64'(req_be));
      if (t_wr) chk(ad_o == wbase + 32'(nx), "R3", "write word", 64'(ad_o), 64'(wbase + 32'(nx)));
      else begin
        chk(!ad_oe, "R8", "ad released in read data", 64'(ad_oe), 64'd0);
        ad_i = rpat(nx);
      end
      if (t_s == 0) chk(frame_o == (nx == t_len - 1), "R4", "frame on last phase only",
                        64'(frame_o), 64'(nx == t_len - 1));
      nx++;
    end
  endtask

  task automatic run(input bit dual, input bit wr, input int rlen, input int d, input int t,
                     input int s, input int exp_st, input int exp_x, input int exp_done);
    logic [63:0] addr;
    logic [3:0] cmd;
    int rc;
    bit fin;
    rc = 0; fin = 0; nx = 0;
    addr = {dual ? 32'h0000_0100 + 32'(rlen) : 32'h0, 32'h4000_0040 + 32'(rlen * 16 + t)};
    cmd  = wr ? 4'h7 : 4'h6;
    t_d = d; t_t = t; t_s = s; t_wr = wr;
    t_len = (rlen == 0) ? 1 : rlen;
    wbase = {8'hA0, 8'(rlen), 8'(t), 8'(dual)};
    rbase = {8'h5C, 8'(t), 8'(rlen), 8'(s)};
    req_addr = addr; req_cmd = cmd; req_be = wr ? 4'b0000 : 4'b0011;
    req_write = wr; req_len = LENW'(rlen); req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(frame_oe && !frame_o && busy, "R1", "frame asserted after accept", 64'(frame_o), 64'd0);
    chk(ad_o == addr[31:0], dual ? "R2" : "R1", "low address dword", 64'(ad_o), 64'(addr[31:0]));
    chk(cbe_o == (dual ? 4'b1101 : cmd), dual ? "R2" : "R1", "first command", 64'(cbe_o),
        64'(dual ? 4'b1101 : cmd));
    target(0);
    for (int k = 1; k <= 40 && !fin; k++) begin
      @(posedge clk); @(negedge clk);
      if (rd_valid) begin
        chk(!wr && rd_data == rpat(rc), "R3", "read word", 64'(rd_data), 64'(rpat(rc)));
        rc++;
      end
      if (dual && k == 1) begin
        chk(ad_o == addr[63:32], "R2", "high address dword", 64'(ad_o), 64'(addr[63:32]));
        chk(cbe_o == cmd, "R2", "second phase command", 64'(cbe_o), 64'(cmd));
      end
      if (exp_st == 1 && k == 5) chk(frame_o && !irdy_o, "R5", "frame up first", 64'({frame_o, irdy_o}), 64'b10);
      if (exp_st == 1 && k == 6) chk(frame_o && irdy_o, "R5", "irdy up next", 64'({frame_o, irdy_o}), 64'b11);
      if (done) begin
        chk(k == exp_done, "R7", "done timing", 64'(k), 64'(exp_done));
        chk(status == 2'(exp_st), exp_st == 1 ? "R5" : (exp_st == 0 ? "R7" : "R6"), "status",
            64'(status), 64'(exp_st));
        chk(nx == exp_x, "R3", "completed phases", 64'(nx), 64'(exp_x));
        if (!wr) chk(rc == exp_x, "R3", "read words returned", 64'(rc), 64'(exp_x));
        chk(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe && !busy, "R8", "all released",
            64'({frame_oe, irdy_oe, ad_oe, cbe_oe}), 64'd0);
        fin = 1;
      end else target(k);
    end
    if (!fin) chk(1'b0, "R7", "done never seen", 64'd0, 64'(exp_done));
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ad_oe && cbe_oe && ad_o == 32'd0 && cbe_o == 4'd0, "R9", "parking after release",
        64'({ad_oe, cbe_oe}), 64'b11);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; gnt_n = 1'b0;
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; req_cmd = '0; req_be = '0;
    req_addr = '0; req_len = '0; ad_i = '0; wbase = '0; rbase = '0;
    repeat (2) @(negedge clk);
    chk(!frame_oe && !irdy_oe && !ad_oe && !busy && !done, "R7", "reset state",
        64'({frame_oe, irdy_oe, ad_oe, busy, done}), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ad_oe && cbe_oe, "R9", "park after reset", 64'({ad_oe, cbe_oe}), 64'b11);
    for (int du = 0; du < 2; du++)
      for (int w = 0; w < 2; w++)
        for (int ln = 0; ln <= 4; ln++)
          for (int ws = 0; ws < 3; ws++) begin
            int fd, el;
            fd = du ? 3 : 2;
            el = (ln == 0) ? 1 : ln;
            run(bit'(du), bit'(w), ln, 1 + ws % 2, fd + ws, 0, 0, el, fd + ws + el);
          end
    for (int du = 0; du < 2; du++) begin
      run(bit'(du), 1'b0, 1, 0, 0, 0, 1, 0, 7);
      run(bit'(du), 1'b1, 3, 0, 0, 0, 1, 0, 7);
      run(bit'(du), 1'b0, 1, 1, 0, (du ? 3 : 2), 3, 0, (du ? 3 : 2) + 1);
      run(bit'(du), 1'b1, 3, 1, 0, (du ? 3 : 2), 3, 0, (du ? 3 : 2) + 2);
      run(bit'(du), 1'b1, 4, 1, (du ? 3 : 2), (du ? 4 : 3), 2, 3, (du ? 3 : 2) + 3);
      run(bit'(du), 1'b0, 5, 1, (du ? 3 : 2), (du ? 4 : 3), 2, 3, (du ? 3 : 2) + 3);
    end
    gnt_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!ad_oe && !cbe_oe, "R9", "park released on grant loss", 64'({ad_oe, cbe_oe}), 64'd0);
    req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!busy && !frame_oe, "R10", "request ignored without grant", 64'({busy, frame_oe}), 64'd0);
    end
    req_valid = 1'b0;
    gnt_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ad_oe && cbe_oe, "R9", "park on grant return", 64'({ad_oe, cbe_oe}), 64'b11);
    run(1'b0, 1'b1, 2, 1, 2, 0, 0, 2, 4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule